// File: doc/BRIEF.md
# MMC Host Command Sequencer

This block runs the command phase of a memory-card host controller. Software fills in a 6-bit command index, a 32-bit argument (loaded as two 16-bit halves) and a command/data control word through a small word-addressed register port. The command goes out to a card-side request/acknowledge interface only while the card clock is enabled. A command written while the clock is stopped stays pending until software starts the clock. A stop-transfer bit in the control word blocks the launch altogether.

When the card acknowledges, it also returns a response byte count and up to 16 response bytes. The sequencer compares the count with the minimum that the selected response type needs. A short response is flagged as a response timeout. A valid response sets an end-of-command status bit, keeps the response bytes for readback, and, if data is enabled, loads a data-phase byte counter with block count times block length. In both cases an end-of-command event is raised. CRC handling, card signalling and the data FIFOs belong to other blocks.

Top module: `mmc_cmd_seq`

## Requirements
- R1: After reset, status reads 0, the interrupt flags read 0, `card_req`, `cmd_active`, `data_phase` and `irq` are low, and the command index register reads 0x40.
- R2: Writes are masked: control word to 0x3dff, command index to 6 bits, block length to 12 bits, block count to 16 bits, response timeout to 7 bits, read timeout to 16 bits, clock rate to 3 bits. Each reads back the masked value.
- R3: The command index reads back ORed with 0x40. Writing the high-argument register loads argument bits [31:16] from data bits [15:0], and reading it returns them. The low-argument register does the same for bits [15:0].
- R4: A control-word write with bit 10 clear while the clock is enabled launches at once. `card_req` rises on the next cycle with the stored index and argument, and status keeps only bit 8.
- R5: A control-word write while the clock is stopped does not launch. Writing bit 1 of the clock register sets status bit 8 and launches the pending command.
- R6: With control bit 10 set, the command never launches, whether from the control write or from a later clock start.
- R7: Writing bit 0 of the clock register clears status bit 8, sets interrupt flag bit 4 and drops any request or data phase in progress. Bit 0 wins when it is written together with bit 1. Starting the clock clears flag bit 4.
- R8: The response type is control bits [1:0]. Type 0 accepts any count. Types 1 and 3 need at least 4 bytes, and type 2 needs 16. A shorter count sets status bit 1 and returns the sequencer to idle.
- R9: A valid response sets status bit 13. If control bit 2 is set, `data_phase` rises and the byte counter (register 12) loads block count times block length. Otherwise the sequencer goes idle.
- R10: Every accepted acknowledge, whether or not the response is valid, sets interrupt flag bit 2 and pulses `end_cmd_pulse` for one cycle.
- R11: A valid response stores `card_resp`, and registers 16 to 19 return its 32-bit words, lowest word first. A timed-out response leaves them unchanged.
- R12: Writing ones to interrupt register 8 clears those flags. `irq` is high while any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational on `addr` |
| card_req | output | 1 | Command request to the card side |
| card_cmd | output | 6 | Command index for the card |
| card_arg | output | 32 | Command argument for the card |
| card_ack | input | 1 | Card acknowledge with response |
| card_resp_len | input | 5 | Response byte count returned |
| card_resp | input | 128 | Response bytes, byte 0 in bits [7:0] |
| cmd_active | output | 1 | Request or data phase in progress |
| data_phase | output | 1 | Data phase armed after a valid response |
| data_bytes | output | 28 | Data-phase byte count |
| end_cmd_pulse | output | 1 | One-cycle end-of-command event |
| irq | output | 1 | Any interrupt flag set |

## Verification
Every effect of a register write is due one clock after the edge that samples the write. A launch raises `card_req` one cycle after the control or clock write, and status, flags, `data_bytes` and `end_cmd_pulse` settle one cycle after the edge that sees `card_ack`. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs, and the registered outputs are compared against it shortly after each falling edge, so every comparison lands exactly one edge after its cause. Register readbacks are separate checks with values taken from the requirements, read after the outputs have settled. They cover the deferred launch, stop-transfer suppression, each response type at its length limits, and the abort on a clock stop.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

    localparam int ADDR_W   = 5;
    localparam int BLEN_W   = 12;
    localparam int BCNT_W   = 16;
    localparam int CNT_W    = BLEN_W + BCNT_W;
    localparam int IDX_W    = 6;
    localparam int CTRL_W   = 14;
    localparam int SHORT_RSP_BYTES = 4;
    localparam int LONG_RSP_BYTES  = 16;

    // register word addresses
    localparam logic [ADDR_W-1:0] RA_CLK   = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] RA_RATE  = 5'd2;
    localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd3;
    localparam logic [ADDR_W-1:0] RA_RTO   = 5'd4;
    localparam logic [ADDR_W-1:0] RA_DTO   = 5'd5;
    localparam logic [ADDR_W-1:0] RA_BLEN  = 5'd6;
    localparam logic [ADDR_W-1:0] RA_BCNT  = 5'd7;
    localparam logic [ADDR_W-1:0] RA_INT   = 5'd8;
    localparam logic [ADDR_W-1:0] RA_IDX   = 5'd9;
    localparam logic [ADDR_W-1:0] RA_ARGH  = 5'd10;
    localparam logic [ADDR_W-1:0] RA_ARGL  = 5'd11;
    localparam logic [ADDR_W-1:0] RA_BYTES = 5'd12;
    localparam logic [ADDR_W-1:0] RA_RESP  = 5'd16;

    // bit positions
    localparam int CK_STOP   = 0;
    localparam int CK_START  = 1;
    localparam int CT_DATA   = 2;
    localparam int CT_STOPTR = 10;
    localparam int ST_TOUT   = 1;
    localparam int ST_CLKON  = 8;
    localparam int ST_END    = 13;
    localparam int IF_END    = 2;
    localparam int IF_CLKOFF = 4;

    localparam logic [31:0] CTRL_MASK = 32'h0000_3dff;
    localparam logic [31:0] CMD_START_BITS = 32'h0000_0040;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_SHORT  = 2'd1,
        RSP_LONG   = 2'd2,
        RSP_SHORTB = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DATA  = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [2:0]        rate;
        logic [6:0]        rto;
        logic [15:0]       dto;
        logic [BLEN_W-1:0] blen;
        logic [BCNT_W-1:0] bcnt;
        logic [IDX_W-1:0]  idx;
        logic [31:0]       arg;
    } cfg_t;

    function automatic int min_rsp_bytes(rsp_kind_e k);
        case (k)
            RSP_NONE:  return 0;
            RSP_LONG:  return LONG_RSP_BYTES;
            default:   return SHORT_RSP_BYTES;
        endcase
    endfunction

endpackage

// File: rtl/mmc_cmd_regs.sv
module mmc_cmd_regs
    import mmc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL: cfg.ctrl <= CTRL_W'(wr_data & CTRL_MASK);
                RA_RATE: cfg.rate <= wr_data[2:0];
                RA_RTO:  cfg.rto  <= wr_data[6:0];
                RA_DTO:  cfg.dto  <= wr_data[15:0];
                RA_BLEN: cfg.blen <= wr_data[BLEN_W-1:0];
                RA_BCNT: cfg.bcnt <= wr_data[BCNT_W-1:0];
                RA_IDX:  cfg.idx  <= wr_data[IDX_W-1:0];
                RA_ARGH: cfg.arg[31:16] <= wr_data[15:0];
                RA_ARGL: cfg.arg[15:0]  <= wr_data[15:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mmc_cmd_resp.sv
module mmc_cmd_resp
    import mmc_cmd_pkg::*;
#(
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = $clog2(RESP_BYTES + 1)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  rsp_kind_e             kind,
    input  logic [LEN_W-1:0]      resp_len,
    input  logic [RESP_BYTES*8-1:0] resp_data,
    input  logic                  capture,
    input  logic [1:0]            word_sel,
    output logic                  len_ok,
    output logic [31:0]           word_out
);
    localparam int RESP_WORDS = (RESP_BYTES + 3) / 4;

    logic [31:0] words [RESP_WORDS];

    assign len_ok = int'(resp_len) >= min_rsp_bytes(kind);

    for (genvar w = 0; w < RESP_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[w] <= '0;
            else if (capture)
                words[w] <= resp_data[w*32 +: 32];
        end
    end

    always_comb begin
        word_out = '0;
        for (int w = 0; w < RESP_WORDS; w++)
            if (int'(word_sel) == w) word_out = words[w];
    end
endmodule

// File: rtl/mmc_cmd_ctrl.sv
module mmc_cmd_ctrl
    import mmc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_wr,
    input  logic              ctrl_wr,
    input  logic              int_wr,
    input  logic [31:0]       wr_data,
    input  cfg_t              cfg,
    input  logic              card_ack,
    input  logic              len_ok,
    output logic              card_req,
    output logic              ack_take,
    output logic              capture,
    output logic [31:0]       status,
    output logic [31:0]       int_flags,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              cmd_active,
    output logic              data_phase,
    output logic              end_pulse
);
    sq_state_e state;
    logic clk_on, pending, st_tout, st_end, if_end, if_off;

    assign ack_take = (state == SQ_ISSUE) && card_ack && !clk_wr && !ctrl_wr;
    assign capture  = ack_take && len_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            clk_on    <= 1'b0;
            pending   <= 1'b0;
            st_tout   <= 1'b0;
            st_end    <= 1'b0;
            if_end    <= 1'b0;
            if_off    <= 1'b0;
            byte_cnt  <= '0;
            end_pulse <= 1'b0;
        end else begin
            end_pulse <= 1'b0;
            if (int_wr) begin
                if (wr_data[IF_END])    if_end <= 1'b0;
                if (wr_data[IF_CLKOFF]) if_off <= 1'b0;
            end
            if (clk_wr) begin
                if (wr_data[CK_START]) begin
                    clk_on <= 1'b1;
                    if_off <= 1'b0;
                    if (pending && !cfg.ctrl[CT_STOPTR]) begin
                        state   <= SQ_ISSUE;
                        pending <= 1'b0;
                        st_tout <= 1'b0;
                        st_end  <= 1'b0;
                    end
                end
                if (wr_data[CK_STOP]) begin
                    clk_on <= 1'b0;
                    if_off <= 1'b1;
                    state  <= SQ_IDLE;
                end
            end else if (ctrl_wr) begin
                pending <= 1'b1;
                state   <= SQ_IDLE;
                if (!wr_data[CT_STOPTR]) begin
                    st_tout <= 1'b0;
                    st_end  <= 1'b0;
                    if (clk_on) begin
                        state   <= SQ_ISSUE;
                        pending <= 1'b0;
                    end
                end
            end else if (ack_take) begin
                end_pulse <= 1'b1;
                if_end    <= 1'b1;
                if (len_ok) begin
                    st_end <= 1'b1;
                    if (cfg.ctrl[CT_DATA]) begin
                        state    <= SQ_DATA;
                        byte_cnt <= CNT_W'(cfg.bcnt) * CNT_W'(cfg.blen);
                    end else begin
                        state <= SQ_IDLE;
                    end
                end else begin
                    st_tout <= 1'b1;
                    state   <= SQ_IDLE;
                end
            end
        end
    end

    always_comb begin
        status = '0;
        status[ST_TOUT]  = st_tout;
        status[ST_CLKON] = clk_on;
        status[ST_END]   = st_end;
        int_flags = '0;
        int_flags[IF_END]    = if_end;
        int_flags[IF_CLKOFF] = if_off;
    end

    assign card_req   = (state == SQ_ISSUE);
    assign cmd_active = (state != SQ_IDLE);
    assign data_phase = (state == SQ_DATA);

    // R5: a request is only ever driven with the clock running
    p_req_needs_clk_r5: assert property (@(posedge clk) disable iff (rst)
        card_req |-> status[ST_CLKON]);

    // R7: stop-clock write drops the clock, the request and raises the flag
    p_stop_clock_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_wr && wr_data[CK_STOP]) |=> (!status[ST_CLKON] && !card_req && !data_phase && int_flags[IF_CLKOFF]));

    // R10: an accepted acknowledge always yields the end-of-command event
    p_end_event_r10: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> (end_pulse && int_flags[IF_END]));

    // R8: a short response reports timeout and idles
    p_short_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !len_ok) |=> (status[ST_TOUT] && !cmd_active));

    // R8: timeout and end-of-response never reported together
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(status[ST_TOUT] && status[ST_END]));

    // R9: a valid response with data enabled arms the data phase
    p_data_arm_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_take && len_ok && cfg.ctrl[CT_DATA]) |=> (data_phase && status[ST_END]));
endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
    import mmc_cmd_pkg::*;
#(
    parameter int RESP_BYTES = 16,
    parameter int LEN_W      = $clog2(RESP_BYTES + 1)
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wr_data,
    output logic [31:0]             rd_data,
    output logic                    card_req,
    output logic [IDX_W-1:0]        card_cmd,
    output logic [31:0]             card_arg,
    input  logic                    card_ack,
    input  logic [LEN_W-1:0]        card_resp_len,
    input  logic [RESP_BYTES*8-1:0] card_resp,
    output logic                    cmd_active,
    output logic                    data_phase,
    output logic [CNT_W-1:0]        data_bytes,
    output logic                    end_cmd_pulse,
    output logic                    irq
);
    cfg_t        cfg;
    logic        len_ok, ack_take, capture;
    logic [31:0] status, int_flags, resp_word;

    wire clk_wr  = wr_en && (addr == RA_CLK);
    wire ctrl_wr = wr_en && (addr == RA_CTRL);
    wire int_wr  = wr_en && (addr == RA_INT);

    mmc_cmd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    mmc_cmd_resp #(.RESP_BYTES(RESP_BYTES), .LEN_W(LEN_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .kind      (rsp_kind_e'(cfg.ctrl[1:0])),
        .resp_len  (card_resp_len),
        .resp_data (card_resp),
        .capture   (capture),
        .word_sel  (addr[1:0]),
        .len_ok    (len_ok),
        .word_out  (resp_word)
    );

    mmc_cmd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clk_wr     (clk_wr),
        .ctrl_wr    (ctrl_wr),
        .int_wr     (int_wr),
        .wr_data    (wr_data),
        .cfg        (cfg),
        .card_ack   (card_ack),
        .len_ok     (len_ok),
        .card_req   (card_req),
        .ack_take   (ack_take),
        .capture    (capture),
        .status     (status),
        .int_flags  (int_flags),
        .byte_cnt   (data_bytes),
        .cmd_active (cmd_active),
        .data_phase (data_phase),
        .end_pulse  (end_cmd_pulse)
    );

    assign card_cmd = cfg.idx;
    assign card_arg = cfg.arg;
    assign irq      = |int_flags;

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_STAT:  rd_data = status;
            RA_RATE:  rd_data = 32'(cfg.rate);
            RA_CTRL:  rd_data = 32'(cfg.ctrl);
            RA_RTO:   rd_data = 32'(cfg.rto);
            RA_DTO:   rd_data = 32'(cfg.dto);
            RA_BLEN:  rd_data = 32'(cfg.blen);
            RA_BCNT:  rd_data = 32'(cfg.bcnt);
            RA_INT:   rd_data = int_flags;
            RA_IDX:   rd_data = 32'(cfg.idx) | CMD_START_BITS;
            RA_ARGH:  rd_data = {16'h0, cfg.arg[31:16]};
            RA_ARGL:  rd_data = {16'h0, cfg.arg[15:0]};
            RA_BYTES: rd_data = 32'(data_bytes);
            default:  if (addr[4:2] == RA_RESP[4:2]) rd_data = resp_word;
        endcase
    end
endmodule

// File: tb/mmc_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module mmc_cmd_seq_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic         card_req;
    logic [5:0]   card_cmd;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic [4:0]   card_resp_len = '0;
    logic [127:0] card_resp = '0;
    logic         cmd_active, data_phase, end_cmd_pulse, irq;
    logic [27:0]  data_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mmc_cmd_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .card_req(card_req), .card_cmd(card_cmd),
        .card_arg(card_arg), .card_ack(card_ack), .card_resp_len(card_resp_len),
        .card_resp(card_resp), .cmd_active(cmd_active), .data_phase(data_phase),
        .data_bytes(data_bytes), .end_cmd_pulse(end_cmd_pulse), .irq(irq)
    );

    // behavioural reference model
    bit        m_clk_on, m_pend, m_busy, m_phase, m_tout, m_end, m_pulse;
    int        m_int;
    int        m_ctrl, m_blen, m_bcnt, m_idx;
    bit [31:0] m_arg;
    int        m_bytes;

    always @(posedge clk) begin
        if (rst) begin
            m_clk_on = 0; m_pend = 0; m_busy = 0; m_phase = 0;
            m_tout = 0; m_end = 0; m_pulse = 0; m_int = 0;
            m_ctrl = 0; m_blen = 0; m_bcnt = 0; m_idx = 0; m_arg = 0; m_bytes = 0;
        end else begin
            bit wclk, wctl;
            m_pulse = 0;
            wclk = wr_en && addr == 0;
            wctl = wr_en && addr == 3;
            if (wr_en) begin
                case (addr)
                    3:  m_ctrl = wr_data & 32'h3dff;
                    6:  m_blen = wr_data & 32'hfff;
                    7:  m_bcnt = wr_data & 32'hffff;
                    8:  m_int  = m_int & ~wr_data & 32'h14;
                    9:  m_idx  = wr_data & 32'h3f;
                    10: m_arg[31:16] = wr_data[15:0];
                    11: m_arg[15:0]  = wr_data[15:0];
                    default: ;
                endcase
            end
            if (wclk) begin
                if (wr_data[1]) begin
                    m_clk_on = 1; m_int = m_int & ~32'h10;
                    if (m_pend && !m_ctrl[10]) begin
                        m_busy = 1; m_pend = 0; m_tout = 0; m_end = 0;
                    end
                end
                if (wr_data[0]) begin
                    m_clk_on = 0; m_int = m_int | 32'h10; m_busy = 0; m_phase = 0;
                end
            end else if (wctl) begin
                m_busy = 0; m_phase = 0; m_pend = 1;
                if (!wr_data[10]) begin
                    m_tout = 0; m_end = 0;
                    if (m_clk_on) begin m_busy = 1; m_pend = 0; end
                end
            end else if (m_busy && card_ack) begin
                int need;
                need = (m_ctrl[1:0] == 0) ? 0 : (m_ctrl[1:0] == 2) ? 16 : 4;
                m_pulse = 1; m_int = m_int | 32'h4; m_busy = 0;
                if (int'(card_resp_len) >= need) begin
                    m_end = 1;
                    if (m_ctrl[2]) begin m_phase = 1; m_bytes = m_blen * m_bcnt; end
                end else begin
                    m_tout = 1;
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // compare registered outputs with the model every cycle
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R4 card_req", 32'(card_req), 32'(m_busy));
            check("R9 data_phase", 32'(data_phase), 32'(m_phase));
            check("R9 cmd_active", 32'(cmd_active), 32'(m_busy | m_phase));
            check("R9 data_bytes", 32'(data_bytes), 32'(m_bytes));
            check("R10 end_cmd_pulse", 32'(end_cmd_pulse), 32'(m_pulse));
            check("R12 irq", 32'(irq), 32'(m_int != 0));
            if (card_req) begin
                check("R4 card_cmd", 32'(card_cmd), 32'(m_idx));
                check("R4 card_arg", card_arg, m_arg);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #2;
        check(tag, rd_data, exp);
    endtask

    task automatic ack(input logic [4:0] len, input logic [127:0] data);
        @(negedge clk);
        for (int n = 0; n < 20 && !card_req; n++) @(negedge clk);
        card_ack = 1; card_resp_len = len; card_resp = data;
        @(negedge clk);
        card_ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst = 0;
        // R1 reset state
        rd(1, 32'h0, "R1 status");
        rd(8, 32'h0, "R1 int flags");
        rd(9, 32'h40, "R1 index");
        check("R1 card_req", 32'(card_req), 32'h0);

        // R2 masks, R3 index and argument readback
        wr(3, 32'hffff_ffff); rd(3, 32'h3dff, "R2 ctrl mask");
        wr(9, 32'hffff_ffff); rd(9, 32'h7f, "R3 index or 0x40");
        wr(2, 32'hff);        rd(2, 32'h7, "R2 rate");
        wr(4, 32'hff);        rd(4, 32'h7f, "R2 resp timeout");
        wr(5, 32'h12345);     rd(5, 32'h2345, "R2 read timeout");
        wr(6, 32'hffff);      rd(6, 32'hfff, "R2 block length");
        wr(7, 32'h1ffff);     rd(7, 32'hffff, "R2 block count");
        wr(10, 32'h1234_abcd); rd(10, 32'habcd, "R3 arg high");
        wr(11, 32'h0000_5678); rd(11, 32'h5678, "R3 arg low");
        check("R6 no launch with stop-transfer", 32'(card_req), 32'h0);

        // R5 deferred launch
        wr(9, 32'h11);
        wr(3, 32'h1);
        idle(3);
        check("R5 pending while clock stopped", 32'(card_req), 32'h0);
        wr(0, 32'h2);
        check("R5 launch on clock start", 32'(card_req), 32'h1);
        rd(1, 32'h100, "R5 status clock on");
        ack(5'd4, {64'h0, 64'hddcc_bbaa_4433_2211});
        rd(1, 32'h2100, "R9 end of response");
        rd(8, 32'h4, "R10 end flag");
        rd(16, 32'h4433_2211, "R11 response word 0");
        rd(17, 32'hddcc_bbaa, "R11 response word 1");

        // R4 immediate launch, R8 response checks
        wr(3, 32'h2);
        check("R4 immediate launch", 32'(card_req), 32'h1);
        rd(1, 32'h100, "R4 status cleared");
        ack(5'd15, {128{1'b1}});
        rd(1, 32'h102, "R8 long response short");
        rd(16, 32'h4433_2211, "R11 timeout keeps response");
        wr(3, 32'h2); ack(5'd16, 128'h1);
        rd(1, 32'h2100, "R8 long response exact");
        wr(3, 32'h0); ack(5'd0, 128'h0);
        rd(1, 32'h2100, "R8 type 0 no response");
        wr(3, 32'h3); ack(5'd3, 128'h0);
        rd(1, 32'h102, "R8 type 3 three bytes");
        rd(8, 32'h4, "R10 flag on timeout");

        // R9 data phase
        wr(6, 32'd512); wr(7, 32'd3);
        wr(3, 32'h5); ack(5'd4, 128'h0);
        check("R9 data phase", 32'(data_phase), 32'h1);
        rd(12, 32'd1536, "R9 byte count");

        // R7 stop clock aborts, R12 clearing
        wr(0, 32'h1);
        check("R7 data phase dropped", 32'(data_phase), 32'h0);
        rd(1, 32'h2000, "R7 clock off");
        rd(8, 32'h14, "R7 clock-off flag");
        wr(8, 32'h4); rd(8, 32'h10, "R12 write-one clear");
        wr(0, 32'h2); rd(8, 32'h0, "R7 start clears flag");
        check("R12 irq low", 32'(irq), 32'h0);
        check("R5 no pending command", 32'(card_req), 32'h0);

        // R6 stop-transfer suppression
        wr(3, 32'h401); idle(2);
        check("R6 no launch", 32'(card_req), 32'h0);
        wr(0, 32'h1); wr(0, 32'h2); idle(2);
        check("R6 no launch on restart", 32'(card_req), 32'h0);

        // R7 abort of a pending request, stop wins over start
        wr(3, 32'h1);
        check("R4 relaunch", 32'(card_req), 32'h1);
        wr(0, 32'h3);
        check("R7 request dropped", 32'(card_req), 32'h0);
        rd(1, 32'h0, "R7 stop wins");
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule